// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sits next to a small 8-bit processor core and moves it between normal running and two sleep depths that software requests. In the light sleep, only the core clock stops: peripheral clocks and the oscillator keep running, so timers and serial units still work. In the deep sleep, the oscillator enable drops, and every clock stops with it. Each depth has its own exit sources. A deep-sleep wake by interrupt first re-enables the oscillator and then waits a restart delay, counted on a slow free-running reference tick, before the core may run.

Software asks for a mode by writing a two-bit request field. The block also drives the override levels for the address-latch and program-fetch strobes. It flags port 0 to float and selects what port 2 holds while asleep on external program memory. It also opens a RAM write-block window when a hardware reset ends light sleep. SFR and RAM contents are never touched by the sequencer; it only gates clocks and writes.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: While in light sleep, `cpu_clk_en` is 0 and `per_clk_en` and `osc_en` are both 1.
- R2: While in deep sleep, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0.
- R3: Software requests a mode by a `ctl_wr` pulse, and the field loads only while running. Field bit 1 requests deep sleep and bit 0 requests light sleep; bit 1 wins when both are set. The mode is entered on the clock edge after the field holds a nonzero value. A write made while not running is ignored.
- R4: Light sleep ends on `irq_pending`, which returns the block to running on the next edge. A hardware reset (`ext_rst`) ends it by opening the write-block window, and `ext_rst` wins when both inputs are high.
- R5: Deep sleep ends on `ext_rst`, which returns the block straight to running. An external interrupt (`ext_irq_req`) ends it only if `ext_irq_level` was 1 on the edge that entered deep sleep. With an edge-configured source, or with `irq_pending`, the block stays asleep.
- R6: After an interrupt wake from deep sleep, `osc_en` is 1 while both clock enables stay 0. This lasts until RESTART_TICKS `ref_tick` pulses have been seen. The block then runs again, and `wake_ready` is 1 for exactly that first running cycle.
- R7: `ext_rst` during the restart delay returns the block to running at once, and `wake_ready` does not pulse.
- R8: `strb_force` is 1 in both sleep depths and during the restart delay, and 0 otherwise. `strb_level` is 1 in light sleep and 0 in all other states.
- R9: When `ext_rst` ends light sleep, `ram_wr_inhibit` is 1 and `cpu_clk_en` is 1 for INH_CYC cycles. The block then runs with the inhibit at 0. `ext_rst` inside the window does not extend it.
- R10: With `ext_prog_mem` = 1, `p0_float` is 1 in both sleep depths and in the restart delay. `p2_addr` is 1 in light sleep only. With `ext_prog_mem` = 0, both are 0.
- R11: `mode_bits` reads 00 after every return to running and after any `ext_rst`. `ext_rst` also beats a write in the same cycle.
- R12: After `rst_n` is low on a clock edge, the block is running: clocks and oscillator are enabled, `mode_bits` is 00, and all override, inhibit and ready outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| ref_tick | input | 1 | One-cycle pulse from the slow free-running reference |
| ctl_wr | input | 1 | Write strobe for the mode request field |
| ctl_wdata | input | 2 | Request field: bit 1 deep sleep, bit 0 light sleep |
| irq_pending | input | 1 | Any enabled interrupt is pending |
| ext_irq_req | input | 1 | Enabled external interrupt pin is active |
| ext_irq_level | input | 1 | External interrupt configured level-sensitive |
| ext_rst | input | 1 | Hardware reset pin of the processor, active high |
| ext_prog_mem | input | 1 | Core fetches from external program memory |
| mode_bits | output | 2 | Current request field |
| cpu_clk_en | output | 1 | Core clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |
| strb_force | output | 1 | Override the address-latch and program-fetch strobes |
| strb_level | output | 1 | Level driven on both strobes when overridden |
| p0_float | output | 1 | Port 0 drivers released |
| p2_addr | output | 1 | Port 2 holds address (1) or data (0) |
| wake_ready | output | 1 | One-cycle flag: restart delay expired |

## Verification
A wrong state inside the sequencer shows up at the ports on the very next cycle. Every state has its own clock, oscillator, strobe and inhibit pattern, so any state taken in error breaks that pattern at once. A restart counter that is off by one moves the `wake_ready` pulse and the return of `cpu_clk_en` by a whole reference period. A stale level-configuration latch shows as a deep sleep that wakes or fails to wake on the external pin. The bench compares every output with an independent model on every clock, so the first cycle of divergence is reported.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power sequencer.
// Assumes: one state active at a time; output pattern depends only on state
// and the external-program-memory strap.
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_PDOWN  = 3'd2,
        ST_WARM   = 3'd3,
        ST_RSTWIN = 3'd4
    } lpm_state_e;

    typedef struct packed {
        logic cpu_clk_en;
        logic per_clk_en;
        logic osc_en;
        logic ram_wr_inhibit;
        logic strb_force;
        logic strb_level;
        logic p0_float;
        logic p2_addr;
    } lpm_out_s;

    // Maps a state and the program-memory strap onto the pin-level controls.
    function automatic lpm_out_s lpm_decode(lpm_state_e st, logic ext_prog);
        lpm_out_s o;
        o = '0;
        case (st)
            ST_RUN: begin
                o.cpu_clk_en = 1'b1;
                o.per_clk_en = 1'b1;
                o.osc_en     = 1'b1;
            end
            ST_IDLE: begin
                o.per_clk_en = 1'b1;
                o.osc_en     = 1'b1;
                o.strb_force = 1'b1;
                o.strb_level = 1'b1;
                o.p0_float   = ext_prog;
                o.p2_addr    = ext_prog;
            end
            ST_PDOWN: begin
                o.strb_force = 1'b1;
                o.p0_float   = ext_prog;
            end
            ST_WARM: begin
                o.osc_en     = 1'b1;
                o.strb_force = 1'b1;
                o.p0_float   = ext_prog;
            end
            ST_RSTWIN: begin
                o.cpu_clk_en     = 1'b1;
                o.per_clk_en     = 1'b1;
                o.osc_en         = 1'b1;
                o.ram_wr_inhibit = 1'b1;
            end
            default: o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/lpm_mode_reg.sv
// Request field written by software.
// Loads only while the core runs; hardware clear wins over a write.
module lpm_mode_reg #(
    parameter int FIELD_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [FIELD_W-1:0] wdata,
    input  logic               accept,
    input  logic               clr,
    output logic [FIELD_W-1:0] bits
);

    // Holds the request field; clear has priority over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bits <= '0;
        end else if (wr && accept) begin
            bits <= wdata;
        end
    end

endmodule

// File: rtl/lpm_wake_timer.sv
// Shared delay counter: counts slow reference ticks for the oscillator
// restart, or plain clock cycles for the RAM write-block window.
// Assumes: at most one of slow_en / fast_en is high; clear restarts from zero.
module lpm_wake_timer #(
    parameter int SLOW_LIM = 16,
    parameter int FAST_LIM = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic slow_en,
    input  logic fast_en,
    input  logic ref_tick,
    output logic expire
);

    localparam int LIM_MAX = (SLOW_LIM > FAST_LIM) ? SLOW_LIM : FAST_LIM;
    localparam int CW      = $clog2(LIM_MAX + 1);
    localparam logic [CW-1:0] SLOW_END = CW'(SLOW_LIM - 1);
    localparam logic [CW-1:0] FAST_END = CW'(FAST_LIM - 1);

    logic [CW-1:0] cnt_q;
    logic          step;
    logic [CW-1:0] end_v;

    // Selects the advance condition and terminal count for the active use.
    always_comb begin
        step   = (slow_en && ref_tick) || fast_en;
        end_v  = slow_en ? SLOW_END : FAST_END;
        expire = step && (cnt_q == end_v);
    end

    // Advances the count; wraps to zero on expiry or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || expire) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/lpm_fsm.sv
// Sleep-state sequencer: picks the next state from the request field, the
// wake sources and the delay timer, and produces the clear and ready pulses.
// Assumes: inputs are synchronous to clk; ext_rst outranks every other source.
module lpm_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_idle,
    input  logic       bit_pd,
    input  logic       irq_pending,
    input  logic       ext_irq_req,
    input  logic       ext_irq_level,
    input  logic       ext_rst,
    input  logic       tmr_expire,
    output lpm_state_e st,
    output logic       lvl_cfg_q,
    output logic       bits_clr,
    output logic       tmr_clear,
    output logic       tmr_slow,
    output logic       tmr_fast,
    output logic       wake_ready
);

    lpm_state_e st_d;
    logic       ready_d;
    logic       enter_pd;

    // Next-state choice for each state, reset first.
    always_comb begin
        st_d = st;
        case (st)
            ST_RUN: begin
                if (!ext_rst) begin
                    if (bit_pd)        st_d = ST_PDOWN;
                    else if (bit_idle) st_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (ext_rst)          st_d = ST_RSTWIN;
                else if (irq_pending) st_d = ST_RUN;
            end
            ST_PDOWN: begin
                if (ext_rst)                         st_d = ST_RUN;
                else if (ext_irq_req && lvl_cfg_q)   st_d = ST_WARM;
            end
            ST_WARM: begin
                if (ext_rst || tmr_expire) st_d = ST_RUN;
            end
            ST_RSTWIN: begin
                if (tmr_expire) st_d = ST_RUN;
            end
            default: st_d = ST_RUN;
        endcase
    end

    // Side signals: field clear, timer mode, ready and level-latch enable.
    always_comb begin
        bits_clr  = ext_rst || ((st != ST_RUN) && (st_d == ST_RUN));
        tmr_slow  = (st == ST_WARM);
        tmr_fast  = (st == ST_RSTWIN);
        tmr_clear = !(tmr_slow || tmr_fast);
        ready_d   = (st == ST_WARM) && !ext_rst && tmr_expire;
        enter_pd  = (st == ST_RUN) && !ext_rst && bit_pd;
    end

    // State, ready flag and the level-sensitivity snapshot taken on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_RUN;
            wake_ready <= 1'b0;
            lvl_cfg_q  <= 1'b0;
        end else begin
            st         <= st_d;
            wake_ready <= ready_d;
            if (enter_pd) lvl_cfg_q <= ext_irq_level;
        end
    end

endmodule

// File: rtl/lpm_seq_ctrl.sv
// Top of the low-power sequencer: request field, state machine, shared delay
// timer and the state-to-pin decode.
// Assumes: ref_tick is a single-cycle pulse from a slower free-running clock
// domain already brought into clk; ext_rst is the synchronised reset pin.
module lpm_seq_ctrl
    import lpm_pkg::*;
#(
    parameter int RESTART_TICKS = 16,
    parameter int INH_CYC       = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       ctl_wr,
    input  logic [1:0] ctl_wdata,
    input  logic       irq_pending,
    input  logic       ext_irq_req,
    input  logic       ext_irq_level,
    input  logic       ext_rst,
    input  logic       ext_prog_mem,
    output logic [1:0] mode_bits,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       ram_wr_inhibit,
    output logic       strb_force,
    output logic       strb_level,
    output logic       p0_float,
    output logic       p2_addr,
    output logic       wake_ready
);

    lpm_state_e st;
    lpm_out_s   pins;
    logic       lvl_q;
    logic       bits_clr;
    logic       tmr_clear;
    logic       tmr_slow;
    logic       tmr_fast;
    logic       tmr_expire;

    lpm_mode_reg #(.FIELD_W(2)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ctl_wr),
        .wdata  (ctl_wdata),
        .accept (st == ST_RUN),
        .clr    (bits_clr),
        .bits   (mode_bits)
    );

    lpm_wake_timer #(
        .SLOW_LIM (RESTART_TICKS),
        .FAST_LIM (INH_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tmr_clear),
        .slow_en  (tmr_slow),
        .fast_en  (tmr_fast),
        .ref_tick (ref_tick),
        .expire   (tmr_expire)
    );

    lpm_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_idle      (mode_bits[0]),
        .bit_pd        (mode_bits[1]),
        .irq_pending   (irq_pending),
        .ext_irq_req   (ext_irq_req),
        .ext_irq_level (ext_irq_level),
        .ext_rst       (ext_rst),
        .tmr_expire    (tmr_expire),
        .st            (st),
        .lvl_cfg_q     (lvl_q),
        .bits_clr      (bits_clr),
        .tmr_clear     (tmr_clear),
        .tmr_slow      (tmr_slow),
        .tmr_fast      (tmr_fast),
        .wake_ready    (wake_ready)
    );

    // Drives the pin-level controls from the current state.
    always_comb begin
        pins           = lpm_decode(st, ext_prog_mem);
        cpu_clk_en     = pins.cpu_clk_en;
        per_clk_en     = pins.per_clk_en;
        osc_en         = pins.osc_en;
        ram_wr_inhibit = pins.ram_wr_inhibit;
        strb_force     = pins.strb_force;
        strb_level     = pins.strb_level;
        p0_float       = pins.p0_float;
        p2_addr        = pins.p2_addr;
    end

endmodule

// File: rtl/lpm_seq_chk.sv
// Property checker for the low-power sequencer, bound into the top module.
module lpm_seq_chk
    import lpm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input lpm_state_e st,
    input logic       lvl_q,
    input logic       ext_rst,
    input logic       ext_irq_req,
    input logic [1:0] mode_bits,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       osc_en,
    input logic       ram_wr_inhibit,
    input logic       strb_force,
    input logic       strb_level,
    input logic       wake_ready
);

    // R1
    idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!cpu_clk_en && per_clk_en && osc_en));

    // R2
    pd_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PDOWN) |-> (!cpu_clk_en && !per_clk_en && !osc_en));

    // R3
    pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_RUN && $past(mode_bits[1]) && !$past(ext_rst))
        |-> (st == ST_PDOWN));

    // R5
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PDOWN && !ext_rst && !(ext_irq_req && lvl_q))
        |=> (st == ST_PDOWN));

    // R6
    ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ready |-> (cpu_clk_en && $past(st) == ST_WARM));

    // R8
    strobe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (strb_force && !strb_level));

    // R9
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_inhibit |-> (cpu_clk_en && mode_bits == 2'b00));

    // R11
    clr_on_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && $past(st) != ST_RUN) |-> (mode_bits == 2'b00));

endmodule

bind lpm_seq_ctrl lpm_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .st             (st),
    .lvl_q          (lvl_q),
    .ext_rst        (ext_rst),
    .ext_irq_req    (ext_irq_req),
    .mode_bits      (mode_bits),
    .cpu_clk_en     (cpu_clk_en),
    .per_clk_en     (per_clk_en),
    .osc_en         (osc_en),
    .ram_wr_inhibit (ram_wr_inhibit),
    .strb_force     (strb_force),
    .strb_level     (strb_level),
    .wake_ready     (wake_ready)
);

// File: tb/sim_lpm_seq_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus directed
// checks at the requirement boundaries.
module sim_lpm_seq_ctrl;

    localparam int RT  = 4;
    localparam int INH = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [1:0] ctl_wdata = 2'b00;
    logic       irq_pending = 1'b0;
    logic       ext_irq_req = 1'b0;
    logic       ext_irq_level = 1'b0;
    logic       ext_rst = 1'b0;
    logic       ext_prog_mem = 1'b0;
    logic [1:0] mode_bits;
    logic       cpu_clk_en, per_clk_en, osc_en, ram_wr_inhibit;
    logic       strb_force, strb_level, p0_float, p2_addr, wake_ready;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    bit done = 1'b0;

    lpm_seq_ctrl #(.RESTART_TICKS(RT), .INH_CYC(INH)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .irq_pending(irq_pending),
        .ext_irq_req(ext_irq_req), .ext_irq_level(ext_irq_level),
        .ext_rst(ext_rst), .ext_prog_mem(ext_prog_mem),
        .mode_bits(mode_bits), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_en(osc_en),
        .ram_wr_inhibit(ram_wr_inhibit), .strb_force(strb_force),
        .strb_level(strb_level), .p0_float(p0_float), .p2_addr(p2_addr),
        .wake_ready(wake_ready)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Slow reference: one-cycle pulse every fifth clock.
    int div = 0;
    always @(negedge clk) begin
        div      <= (div == 4) ? 0 : div + 1;
        ref_tick <= (div == 4);
    end

    // Reference model: 0 run, 1 light sleep, 2 deep sleep, 3 restart, 4 window.
    int m_st = 0, m_bits = 0, m_cnt = 0, m_lvl = 0, m_rdy = 0;
    bit started = 1'b0;
    always @(posedge clk) begin
        int nx, nb;
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_bits = 0; m_cnt = 0; m_lvl = 0; m_rdy = 0;
        end else begin
            nx = m_st; nb = m_bits; m_rdy = 0;
            if (m_st == 0) begin
                if (!ext_rst && m_bits >= 2) begin nx = 2; m_lvl = ext_irq_level; end
                else if (!ext_rst && m_bits == 1) nx = 1;
            end else if (m_st == 1) begin
                if (ext_rst) nx = 4; else if (irq_pending) nx = 0;
            end else if (m_st == 2) begin
                if (ext_rst) nx = 0; else if (ext_irq_req && m_lvl == 1) nx = 3;
            end else if (m_st == 3) begin
                if (ref_tick) m_cnt++;
                if (ext_rst) nx = 0;
                else if (m_cnt == RT) begin nx = 0; m_rdy = 1; end
            end else begin
                m_cnt++;
                if (m_cnt == INH) nx = 0;
            end
            if (ext_rst) nb = 0;
            else if (m_st != 0 && nx == 0) nb = 0;
            else if (ctl_wr && m_st == 0) nb = ctl_wdata;
            if (nx != m_st) m_cnt = 0;
            m_st = nx; m_bits = nb;
        end
        started = 1'b1;
        #1;
        if (started && !done) begin
            check("R11 mode_bits", mode_bits, m_bits);
            check("R1 cpu_clk_en", cpu_clk_en, (m_st == 0 || m_st == 4));
            check("R2 per_clk_en", per_clk_en, (m_st == 0 || m_st == 1 || m_st == 4));
            check("R2 osc_en", osc_en, (m_st != 2));
            check("R9 ram_wr_inhibit", ram_wr_inhibit, (m_st == 4));
            check("R8 strb_force", strb_force, (m_st >= 1 && m_st <= 3));
            check("R8 strb_level", strb_level, (m_st == 1));
            check("R10 p0_float", p0_float, ext_prog_mem && (m_st >= 1 && m_st <= 3));
            check("R10 p2_addr", p2_addr, ext_prog_mem && (m_st == 1));
            check("R6 wake_ready", wake_ready, m_rdy);
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        ticks(1);
        ctl_wr = 1'b0; ctl_wdata = 2'b00;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cyc > 5000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        bit seen;
        ticks(3);
        // R12 reset state
        check("R12 cpu_clk_en", cpu_clk_en, 1);
        check("R12 mode_bits", mode_bits, 0);
        rst_n = 1'b1;
        ticks(2);

        // R1 light sleep, R3 write ignored while asleep, R4 interrupt exit
        wr(2'b01);
        ticks(3);
        check("R1 cpu off", cpu_clk_en, 0);
        check("R1 per on", per_clk_en, 1);
        check("R8 level high", strb_level, 1);
        wr(2'b10);
        ticks(1);
        check("R3 ignored write", mode_bits, 1);
        irq_pending = 1'b1; ticks(1); irq_pending = 1'b0;
        ticks(2);
        check("R4 irq exit", cpu_clk_en, 1);
        check("R11 cleared", mode_bits, 0);
        ticks(3);
        check("R3 no late entry", cpu_clk_en, 1);

        // R3 deep sleep priority, R5 edge-configured source ignored
        ext_irq_level = 1'b0;
        wr(2'b11);
        ticks(3);
        check("R3 priority", osc_en, 0);
        check("R8 level low", strb_level, 0);
        ext_irq_req = 1'b1; irq_pending = 1'b1; ticks(3);
        ext_irq_level = 1'b1; ticks(3);
        check("R5 no edge wake", osc_en, 0);
        ext_irq_req = 1'b0; irq_pending = 1'b0;
        ext_rst = 1'b1; ticks(1); ext_rst = 1'b0;
        ticks(1);
        check("R5 reset exit", cpu_clk_en, 1);

        // R6 level wake and restart delay
        wr(2'b10);
        ticks(3);
        ext_irq_req = 1'b1; ticks(1); ext_irq_req = 1'b0;
        ticks(2);
        check("R6 osc during restart", osc_en, 1);
        check("R6 cpu held", cpu_clk_en, 0);
        seen = 1'b0;
        for (int i = 0; i < 60 && !seen; i++) begin
            ticks(1);
            if (wake_ready) seen = 1'b1;
        end
        check("R6 ready pulse", seen, 1);
        ticks(1);
        check("R6 ready single", wake_ready, 0);

        // R7 reset during restart
        wr(2'b10);
        ticks(3);
        ext_irq_req = 1'b1; ticks(1); ext_irq_req = 1'b0;
        ticks(3);
        ext_rst = 1'b1; ticks(1); ext_rst = 1'b0;
        check("R7 back to run", cpu_clk_en, 1);
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            ticks(1);
            if (wake_ready) seen = 1'b1;
        end
        check("R7 no ready", seen, 0);

        // R10 external program memory, R9 write-block window
        ext_prog_mem = 1'b1;
        wr(2'b01);
        ticks(3);
        check("R10 p0 float idle", p0_float, 1);
        check("R10 p2 addr idle", p2_addr, 1);
        ext_rst = 1'b1; irq_pending = 1'b1; ticks(1);
        check("R9 inhibit on", ram_wr_inhibit, 1);
        check("R9 cpu on", cpu_clk_en, 1);
        ticks(1); ext_rst = 1'b0; irq_pending = 1'b0;
        ticks(2);
        check("R9 window closed", ram_wr_inhibit, 0);
        wr(2'b10);
        ticks(3);
        check("R10 p0 float pd", p0_float, 1);
        check("R10 p2 data pd", p2_addr, 0);
        ext_rst = 1'b1; ticks(1); ext_rst = 1'b0;
        ticks(2);
        ext_prog_mem = 1'b0;

        // R11 reset beats a same-cycle write
        ctl_wr = 1'b1; ctl_wdata = 2'b01; ext_rst = 1'b1;
        ticks(1);
        ctl_wr = 1'b0; ctl_wdata = 2'b00; ext_rst = 1'b0;
        ticks(3);
        check("R11 reset beats write", mode_bits, 0);
        check("R11 still running", cpu_clk_en, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule